// File: doc/BRIEF.md
# XOR-Merged Switch Output Port with Recovery Decoder

This block is one output port of a switch that sends flits across the port without waiting for arbitration. Up to `N` inputs offer flits. When one input is valid, its flit goes out in the same cycle, unchanged. When several inputs collide, the port sends the bitwise XOR of every colliding flit and raises a coded flag. In that same cycle a round-robin arbiter picks one competitor, accepts its flit and removes it from the set. Each following cycle repeats this on the inputs still left, until one flit remains. That last flit goes out plain.

A recovery decoder on the port's output turns the link words back into the original flits. It keeps the previous link word in a one-entry register. When that word was coded, the decoder XORs it with the current word and emits the result. When that word was plain, the decoder emits it unchanged. Every flit therefore appears on the decoded output exactly one cycle after its input was granted, and flits leave in grant order.

Each input uses a valid/ready handshake. An input holds its valid and data until it sees ready. Ready is given only in the cycle the flit is sent plain or wins a collision. The link and decoded outputs have no back-pressure and present one word per cycle.

Top module: `xor_merge_port`

## Requirements
- R1: When exactly one input is eligible, `link_valid`=1, `link_coded`=0, `link_data` equals that input's flit, and its `in_ready` bit is 1, all in the same cycle.
- R2: When two or more inputs are eligible, `link_valid`=1, `link_coded`=1, and `link_data` is the bitwise XOR of all eligible flits in that cycle.
- R3: In a cycle with two or more eligible inputs, exactly one `in_ready` bit is 1, on an eligible input, and that input is not eligible in later cycles of the same sequence.
- R4: A collision of K inputs produces K consecutive link words: K-1 coded ones, then a plain one carrying the last remaining flit.
- R5: The arbiter starts its search at the input just above the last collision winner, wrapping from N-1 to 0. The pointer starts at N-1, so input 0 is searched first after reset. Plain single-input sends do not move the pointer.
- R6: Inputs that become valid while a collision sequence is running do not join it and get no ready until the sequence has ended.
- R7: Every granted flit appears on `dec_data` with `dec_valid`=1 in the cycle after its grant. The decoded flits come out in grant order, rebuilt as the XOR of two consecutive link words when the first of them was coded.
- R8: While reset is held, and with no input valid, `link_valid`, `in_ready` and `dec_valid` are all 0 (apart from a decoded flit still due from the previous cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Per-input flit valid, held until ready |
| in_data | input | N*W | Per-input flits, input i at bits [i*W +: W] |
| in_ready | output | N | Per-input accept strobe |
| link_valid | output | 1 | A link word is present |
| link_coded | output | 1 | Link word is an XOR of two or more flits |
| link_data | output | W | Link word |
| dec_valid | output | 1 | A recovered flit is present |
| dec_data | output | W | Recovered flit |

## Verification
The bench drives collisions of two, three and four inputs with different round-robin pointer positions. For each one it predicts the full word sequence. A design that drops a flit from the XOR, or fails to mask the winner, puts a wrong `link_data` on the link. A design that never clears the coded flag produces an extra word at the end of the sequence. A late arrival is raised in the middle of a sequence: a port that lets it join would XOR it in or grant it early. A plain send placed between two collisions shows whether the pointer moves only on collision picks. Decoded flits are compared one cycle after each grant, which exposes a decoder that XORs with the wrong word or drops the final plain flit.

// File: rtl/xmp_pkg.sv
package xmp_pkg;
  // Side information carried with each link word.
  typedef struct packed {
    logic valid;
    logic coded;
  } xmp_tag_t;
endpackage

// File: rtl/xmp_rr_arbiter.sv
module xmp_rr_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         advance,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST_INIT = IW'(N - 1);

  logic [IW-1:0] last_q;
  logic [IW-1:0] pick_idx;

  always_comb begin
    logic found;
    gnt      = '0;
    found    = 1'b0;
    pick_idx = last_q;
    for (int s = 1; s <= N; s++) begin
      int idx;
      idx = (int'(last_q) + s) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        pick_idx = IW'(idx);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= LAST_INIT;
    else if (advance) last_q <= pick_idx;
  end

  // R3
  gnt_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~req) == '0) && $onehot0(gnt));
endmodule

// File: rtl/xmp_encoder.sv
module xmp_encoder
  import xmp_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   in_valid,
  input  logic [N*W-1:0] in_data,
  output logic [N-1:0]   in_ready,
  output logic [W-1:0]   link_data,
  output xmp_tag_t       link_tag
);
  localparam int CW = $clog2(N + 1);

  logic          busy_q;
  logic [N-1:0]  pend_q;
  logic [N-1:0]  cand;
  logic [N-1:0]  gnt;
  logic [CW-1:0] cnt;
  logic          multi;
  logic [W-1:0]  mix [N+1];

  assign cand = busy_q ? (pend_q & in_valid) : in_valid;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + CW'(cand[i]);
  end
  assign multi = (cnt > CW'(1));

  // XOR chain over the eligible flits
  assign mix[0] = '0;
  for (genvar g = 0; g < N; g++) begin : g_mix
    assign mix[g+1] = mix[g] ^ (cand[g] ? in_data[g*W +: W] : '0);
  end

  xmp_rr_arbiter #(.N(N)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (cand),
    .advance (multi),
    .gnt     (gnt)
  );

  assign link_data      = mix[N];
  assign link_tag.valid = |cand;
  assign link_tag.coded = multi;
  assign in_ready       = multi ? gnt : cand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= '0;
    end else begin
      busy_q <= multi;
      pend_q <= cand & ~gnt;
    end
  end

  // R4
  coded_followed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_tag.coded |=> link_tag.valid);
  // R6
  no_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((in_ready & ~pend_q) == '0));
  // R3
  winner_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(link_tag.coded)) |-> ((in_ready & $past(in_ready)) == '0));
endmodule

// File: rtl/xmp_decoder.sv
module xmp_decoder
  import xmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] link_data,
  input  xmp_tag_t     link_tag,
  output logic         dec_valid,
  output logic [W-1:0] dec_data
);
  xmp_tag_t     held_tag_q;
  logic [W-1:0] held_q;

  assign dec_valid = held_tag_q.valid && (!held_tag_q.coded || link_tag.valid);
  assign dec_data  = held_tag_q.coded ? (held_q ^ link_data) : held_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_tag_q <= '0;
      held_q     <= '0;
    end else begin
      held_tag_q <= link_tag;
      held_q     <= link_data;
    end
  end

  // R7
  coded_decodes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_tag.valid && link_tag.coded) |=> dec_valid);
  // R7
  plain_decodes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_tag.valid && !link_tag.coded) |=> (dec_valid && dec_data == $past(link_data)));
endmodule

// File: rtl/xor_merge_port.sv
module xor_merge_port
  import xmp_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   in_valid,
  input  logic [N*W-1:0] in_data,
  output logic [N-1:0]   in_ready,
  output logic           link_valid,
  output logic           link_coded,
  output logic [W-1:0]   link_data,
  output logic           dec_valid,
  output logic [W-1:0]   dec_data
);
  xmp_tag_t tag;

  xmp_encoder #(.N(N), .W(W)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .link_data (link_data),
    .link_tag  (tag)
  );

  xmp_decoder #(.W(W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_data (link_data),
    .link_tag  (tag),
    .dec_valid (dec_valid),
    .dec_data  (dec_data)
  );

  assign link_valid = tag.valid;
  assign link_coded = tag.coded;

  // R8
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !dec_valid);
  // R1
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_ready & ~in_valid) == '0));
endmodule

// File: tb/xor_merge_port_tb.sv
module xor_merge_port_tb;
  localparam int N = 4;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   in_valid = '0;
  logic [N*W-1:0] in_data = '0;
  logic [N-1:0]   in_ready;
  logic           link_valid, link_coded, dec_valid;
  logic [W-1:0]   link_data, dec_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xor_merge_port #(.N(N), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .link_valid(link_valid), .link_coded(link_coded),
    .link_data(link_data), .dec_valid(dec_valid), .dec_data(dec_data)
  );

  // vector: {count[2:0], grant order as 2-bit fields (first in [1:0]), mask[3:0]}
  localparam int NV = 7;
  localparam logic [14:0] VEC [NV] = '{
    {3'd1, 8'h00, 4'h1},
    {3'd3, 8'h24, 4'h7},
    {3'd4, 8'h4E, 4'hF},
    {3'd2, 8'h0D, 4'hA},
    {3'd2, 8'h02, 4'h5},
    {3'd1, 8'h03, 4'h8},
    {3'd2, 8'h03, 4'h9}
  };

  function automatic logic [W-1:0] flit(int e, int i);
    return 16'hC300 ^ W'(e << 8) ^ W'(i * 16'h0111);
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(int e);
    for (int i = 0; i < N; i++) in_data[i*W +: W] = flit(e, i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // reset state, R8
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(!link_valid, "R8 link idle in reset", W'(link_valid), 0);
    chk(in_ready == 0, "R8 no ready in reset", W'(in_ready), 0);
    chk(!dec_valid, "R8 no decode in reset", W'(dec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!link_valid && in_ready == 0, "R8 idle with no valid", W'(link_valid), 0);

    // table walk
    for (int e = 0; e < NV; e++) begin
      logic [3:0] rem;
      int k;
      int prev;
      rem  = VEC[e][3:0];
      k    = int'(VEC[e][14:12]);
      prev = -1;
      load(e);
      for (int j = 0; j < k; j++) begin
        int w;
        logic [W-1:0] x;
        @(negedge clk);
        in_valid = rem;
        #1;
        w = int'(VEC[e][4 + 2*j +: 2]);
        x = '0;
        for (int i = 0; i < N; i++) if (rem[i]) x = x ^ flit(e, i);
        if (j < k - 1)
          chk(link_valid && link_coded && link_data == x, "R2 coded XOR word", link_data, x);
        else if (k == 1)
          chk(link_valid && !link_coded && link_data == x, "R1 single plain pass", link_data, x);
        else
          chk(link_valid && !link_coded && link_data == x, "R4 last flit plain", link_data, x);
        chk(in_ready == N'(1 << w), "R3 R5 round-robin grant", W'(in_ready), W'(1 << w));
        if (prev >= 0)
          chk(dec_valid && dec_data == flit(e, prev), "R7 decoded flit in order",
              dec_data, flit(e, prev));
        rem[w] = 1'b0;
        prev = w;
      end
      @(negedge clk);
      in_valid = '0;
      #1;
      chk(dec_valid && dec_data == flit(e, prev), "R7 final decoded flit", dec_data, flit(e, prev));
      chk(!link_valid, "R8 link idle after sequence", W'(link_valid), 0);
    end

    // late arrival must not join (R6); pointer now at 3 so input 0 wins
    load(7);
    @(negedge clk); in_valid = 4'b0011; #1;
    chk(link_coded && in_ready == 4'b0001, "R6 collision start", W'(in_ready), 16'h1);
    @(negedge clk); in_valid = 4'b0110; #1;
    chk(!link_coded && link_data == flit(7, 1), "R6 late input not mixed", link_data, flit(7, 1));
    chk(in_ready == 4'b0010, "R6 late input not granted", W'(in_ready), 16'h2);
    chk(dec_valid && dec_data == flit(7, 0), "R7 decode after late arrival", dec_data, flit(7, 0));
    @(negedge clk); in_valid = 4'b0100; #1;
    chk(!link_coded && link_data == flit(7, 2) && in_ready == 4'b0100,
        "R1 late input sent alone", link_data, flit(7, 2));
    @(negedge clk); in_valid = '0; #1;
    chk(dec_valid && dec_data == flit(7, 2), "R7 late input decoded", dec_data, flit(7, 2));

    // pointer was left at 0 by the last collision; plain send of input 2 must not move it (R5)
    load(8);
    @(negedge clk); in_valid = 4'b0011; #1;
    chk(in_ready == 4'b0010, "R5 plain send leaves pointer", W'(in_ready), 16'h2);
    chk(link_data == (flit(8, 0) ^ flit(8, 1)), "R2 two-way XOR", link_data, flit(8, 0) ^ flit(8, 1));
    @(negedge clk); in_valid = 4'b0001; #1;
    chk(in_ready == 4'b0001 && !link_coded, "R4 remaining flit plain", W'(in_ready), 16'h1);
    @(negedge clk); in_valid = '0; #1;
    chk(dec_valid && dec_data == flit(8, 0), "R7 two-way decode", dec_data, flit(8, 0));

    // reset in the middle of a collision clears everything (R8)
    load(9);
    @(negedge clk); in_valid = 4'b1111;
    @(negedge clk); rst_n = 1'b0; in_valid = '0;
    @(negedge clk); #1;
    chk(!dec_valid && !link_valid && in_ready == 0, "R8 reset mid sequence", W'(dec_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); in_valid = 4'b0110; #1;
    chk(in_ready == 4'b0010, "R5 pointer back to reset value", W'(in_ready), 16'h2);
    @(negedge clk); in_valid = 4'b0100;
    @(negedge clk); in_valid = '0;
    @(negedge clk);
    finish_run();
  end
endmodule